// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns a serial input line back into characters. Its clock is the receive clock, running at one, sixteen or sixty-four times the bit rate. A start bit is found as a falling edge on the line. With 16 or 64 clocks per bit the line is checked again half a bit later, so a short glitch cannot start a character. After that, every bit is sampled near its centre. The character length (5 to 8 bits), the optional parity bit and its sense are set by static configuration inputs.

Each finished character goes into a single holding register and sets a ready flag. Reading the character with a one-cycle strobe clears the ready flag. Parity, framing and overrun errors are kept in sticky flags. They stay set until an error-clear pulse. While the receive-enable input is low, the receiver stays idle.

Top module: `serial_rx_core`

## Requirements
- R1: `cfg_clk_mul` selects the receive clocks per bit: 01 gives 1, 10 gives 16, 11 gives 64, and 00 also gives 1. In each mode a character sent at that rate is received correctly.
- R2: `cfg_len` selects the data bits: 00 gives 5, 01 gives 6, 10 gives 7, 11 gives 8. Bits arrive LSB first, and `rx_data` bits at and above the length read zero.
- R3: When `cfg_par_en` is 1, one parity bit follows the data. `cfg_par_even` set to 1 means even parity and 0 means odd parity. A parity bit that does not match sets `err_parity`.
- R4: A low level sampled in the stop-bit position sets `err_frame`. The character is still delivered and `rx_ready` is set.
- R5: `rx_ready` rises when a character completes. A one-cycle `rd_strobe` clears it.
- R6: A character that completes while `rx_ready` is still set, with no read in that cycle, sets `err_overrun`. It replaces `rx_data`, and `rx_ready` stays 1.
- R7: `err_parity`, `err_frame` and `err_overrun` stay set through later good characters and reads. An `err_clr` pulse clears all three.
- R8: While `rx_en` is 0, no character is received: `rx_ready` and `rx_data` do not change.
- R9: In the 16 and 64 modes, a low pulse shorter than half a bit is treated as a false start. It produces no character, and the next real character is received intact.
- R10: After reset, `rx_ready`, `rx_data` and all error flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock (1, 16 or 64 per bit) |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rx_en | input | 1 | Receive enable |
| rd_strobe | input | 1 | Read strobe for the holding register, clears ready |
| err_clr | input | 1 | Clears the three error flags |
| cfg_len | input | 2 | Data length code (5 to 8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 means even parity, 0 means odd |
| cfg_clk_mul | input | 2 | Receive clocks per bit code |
| rx_data | output | 8 | Received character |
| rx_ready | output | 1 | A character is waiting to be read |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun error |

## Verification
A line change reaches the frame logic through two synchronizer stages. The start check then falls half a bit after the first low sample, and each later bit follows one full bit time after the previous one. The character result and its flags appear two clocks after the stop-bit centre sample: one clock for the frame register and one for the holding register. That point lies well inside the stop bit. The bench therefore drives each bit for exactly one bit time on falling clock edges, adds one idle bit plus four clocks after each frame, and only then samples outputs on a falling edge. Read and clear strobes last one cycle, and their effect is checked on the next falling edge.

// File: rtl/serrx_pkg.sv
package serrx_pkg;

    localparam int unsigned CHAR_W     = 8;
    localparam int unsigned MAX_FACTOR = 64;
    localparam int unsigned CNT_W      = $clog2(MAX_FACTOR);
    localparam int unsigned IDX_W      = $clog2(CHAR_W);

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              par_bad;
        logic              stop_bad;
    } rx_char_t;

    function automatic int unsigned factor_of(input logic [1:0] code);
        case (code)
            2'b10:   return 16;
            2'b11:   return 64;
            default: return 1;
        endcase
    endfunction

    function automatic int unsigned len_of(input logic [1:0] code);
        return 5 + int'(code);
    endfunction

endpackage

// File: rtl/serrx_sync.sv
module serrx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/serrx_bit_clock.sv
module serrx_bit_clock
    import serrx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic [1:0] mul_code,
    output logic       strobe
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] full_ld;
    logic [CNT_W-1:0] half_ld;

    always_comb begin
        full_ld = CNT_W'(factor_of(mul_code) - 1);
        half_ld = (factor_of(mul_code) > 1) ? CNT_W'(factor_of(mul_code) / 2 - 1) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (restart)     cnt <= half_ld;
        else if (cnt == '0)   cnt <= full_ld;
        else                  cnt <= cnt - 1'b1;
    end

    assign strobe = (cnt == '0);
endmodule

// File: rtl/serrx_frame_fsm.sv
module serrx_frame_fsm
    import serrx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_s,
    input  logic       rx_en,
    input  logic       strobe,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_even,
    input  logic [1:0] cfg_clk_mul,
    output logic       restart,
    output logic       done,
    output rx_char_t   char_out
);
    rx_state_e         state;
    logic              rx_prev;
    logic [IDX_W-1:0]  bit_idx;
    logic [CHAR_W-1:0] shreg;
    logic              par_acc;
    logic              par_bad;
    logic              fall;
    logic              last_bit;

    assign fall     = rx_prev & ~rx_s;
    assign last_bit = (bit_idx == IDX_W'(len_of(cfg_len) - 1));
    assign restart  = (state == RX_IDLE) && rx_en && fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RX_IDLE;
            rx_prev  <= 1'b1;
            bit_idx  <= '0;
            shreg    <= '0;
            par_acc  <= 1'b0;
            par_bad  <= 1'b0;
            done     <= 1'b0;
            char_out <= '0;
        end else begin
            rx_prev <= rx_s;
            done    <= 1'b0;
            if (!rx_en) begin
                state <= RX_IDLE;
            end else begin
                case (state)
                    RX_IDLE: if (fall) begin
                        bit_idx <= '0;
                        shreg   <= '0;
                        par_acc <= 1'b0;
                        par_bad <= 1'b0;
                        state   <= (factor_of(cfg_clk_mul) == 1) ? RX_DATA : RX_START;
                    end
                    RX_START: if (strobe) begin
                        state <= rx_s ? RX_IDLE : RX_DATA;
                    end
                    RX_DATA: if (strobe) begin
                        shreg[bit_idx] <= rx_s;
                        par_acc        <= par_acc ^ rx_s;
                        bit_idx        <= bit_idx + 1'b1;
                        if (last_bit) state <= cfg_par_en ? RX_PAR : RX_STOP;
                    end
                    RX_PAR: if (strobe) begin
                        par_bad <= par_acc ^ rx_s ^ ~cfg_par_even;
                        state   <= RX_STOP;
                    end
                    RX_STOP: if (strobe) begin
                        char_out.data     <= shreg;
                        char_out.par_bad  <= par_bad;
                        char_out.stop_bad <= ~rx_s;
                        done              <= 1'b1;
                        state             <= RX_IDLE;
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/serrx_hold.sv
module serrx_hold
    import serrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  rx_char_t          char_in,
    input  logic              rd_strobe,
    input  logic              err_clr,
    output logic [CHAR_W-1:0] data,
    output logic              ready,
    output logic              pe,
    output logic              fe,
    output logic              oe
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data  <= '0;
            ready <= 1'b0;
            pe    <= 1'b0;
            fe    <= 1'b0;
            oe    <= 1'b0;
        end else begin
            if (err_clr) begin
                pe <= 1'b0;
                fe <= 1'b0;
                oe <= 1'b0;
            end
            if (done) begin
                data  <= char_in.data;
                ready <= 1'b1;
                if (ready && !rd_strobe) oe <= 1'b1;
                if (char_in.par_bad)     pe <= 1'b1;
                if (char_in.stop_bad)    fe <= 1'b1;
            end else if (rd_strobe) begin
                ready <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import serrx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_line,
    input  logic       rx_en,
    input  logic       rd_strobe,
    input  logic       err_clr,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_even,
    input  logic [1:0] cfg_clk_mul,
    output logic [7:0] rx_data,
    output logic       rx_ready,
    output logic       err_parity,
    output logic       err_frame,
    output logic       err_overrun
);
    logic     rx_s;
    logic     strobe;
    logic     restart;
    logic     done;
    rx_char_t char_w;

    serrx_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .din(rx_line), .dout(rx_s)
    );

    serrx_bit_clock u_clk (
        .clk(clk), .rst(rst), .restart(restart),
        .mul_code(cfg_clk_mul), .strobe(strobe)
    );

    serrx_frame_fsm u_fsm (
        .clk(clk), .rst(rst), .rx_s(rx_s), .rx_en(rx_en), .strobe(strobe),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
        .cfg_clk_mul(cfg_clk_mul), .restart(restart), .done(done), .char_out(char_w)
    );

    serrx_hold u_hold (
        .clk(clk), .rst(rst), .done(done), .char_in(char_w),
        .rd_strobe(rd_strobe), .err_clr(err_clr),
        .data(rx_data), .ready(rx_ready),
        .pe(err_parity), .fe(err_frame), .oe(err_overrun)
    );
endmodule

// File: rtl/serrx_checker.sv
module serrx_checker (
    input logic       clk,
    input logic       rst,
    input logic       rx_en,
    input logic       rd_strobe,
    input logic       err_clr,
    input logic [1:0] cfg_len,
    input logic [7:0] rx_data,
    input logic       rx_ready,
    input logic       err_parity,
    input logic       err_frame,
    input logic       err_overrun
);
    assert_ready_falls_on_read_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_ready) |-> $past(rd_strobe));

    assert_flags_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(err_parity) || $fell(err_frame) || $fell(err_overrun)) |-> $past(err_clr));

    assert_overrun_needs_ready_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(err_overrun) |-> ($past(rx_ready) && rx_ready));

    assert_data_moves_with_ready_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_data) |-> rx_ready);

    assert_short_char_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
        ($rose(rx_ready) && cfg_len == 2'b00) |-> (rx_data[7:5] == 3'b000));

    assert_no_rx_when_disabled_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_ready) |-> $past(rx_en));
endmodule

bind serial_rx_core serrx_checker u_chk (
    .clk(clk), .rst(rst), .rx_en(rx_en), .rd_strobe(rd_strobe), .err_clr(err_clr),
    .cfg_len(cfg_len), .rx_data(rx_data), .rx_ready(rx_ready),
    .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun)
);

// File: tb/serial_rx_core_tb.sv
`timescale 1ns/1ps
module serial_rx_core_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic       rx_en = 1'b1;
    logic       rd_strobe = 1'b0;
    logic       err_clr = 1'b0;
    logic [1:0] cfg_len = 2'b11;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic [1:0] cfg_clk_mul = 2'b10;
    logic [7:0] rx_data;
    logic       rx_ready;
    logic       err_parity;
    logic       err_frame;
    logic       err_overrun;

    int total = 0;
    int bad = 0;
    int fac = 16;
    int cyc = 0;

    always #2.5 clk = ~clk;

    serial_rx_core u_dut (
        .clk(clk), .rst(rst), .rx_line(rx_line), .rx_en(rx_en),
        .rd_strobe(rd_strobe), .err_clr(err_clr), .cfg_len(cfg_len),
        .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
        .cfg_clk_mul(cfg_clk_mul), .rx_data(rx_data), .rx_ready(rx_ready),
        .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic [1:0] mul, input logic [1:0] len, input logic pen, input logic peven);
        cfg_clk_mul  = mul;
        cfg_len      = len;
        cfg_par_en   = pen;
        cfg_par_even = peven;
        fac = (mul == 2'b10) ? 16 : (mul == 2'b11) ? 64 : 1;
    endtask

    task automatic drive_bit(input logic b);
        rx_line = b;
        repeat (fac) @(negedge clk);
    endtask

    task automatic send_char(input logic [7:0] d, input bit pflip, input logic stopv);
        int nb;
        int ones;
        logic pbit;
        nb = 5 + int'(cfg_len);
        ones = 0;
        drive_bit(1'b0);
        for (int i = 0; i < nb; i++) begin
            drive_bit(d[i]);
            ones = ones + int'(d[i]);
        end
        if (cfg_par_en) begin
            pbit = cfg_par_even ? logic'(ones % 2) : ~logic'(ones % 2);
            drive_bit(pbit ^ pflip);
        end
        drive_bit(stopv);
        rx_line = 1'b1;
        repeat (fac + 4) @(negedge clk);
    endtask

    task automatic do_read();
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic do_clear();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk(rx_ready == 1'b0, "R10 ready", 32'(rx_ready), 0);
        chk(rx_data == 8'h00, "R10 data", 32'(rx_data), 0);
        chk({err_parity, err_frame, err_overrun} == 3'b000, "R10 flags",
            32'({err_parity, err_frame, err_overrun}), 0);
    endtask

    task automatic t_modes();
        set_mode(2'b10, 2'b11, 1'b0, 1'b0);
        send_char(8'hA5, 1'b0, 1'b1);
        chk(rx_ready == 1'b1, "R5 ready set", 32'(rx_ready), 1);
        chk(rx_data == 8'hA5, "R1 x16 data", 32'(rx_data), 32'hA5);
        do_read();
        chk(rx_ready == 1'b0, "R5 read clears", 32'(rx_ready), 0);
        set_mode(2'b01, 2'b11, 1'b0, 1'b0);
        send_char(8'h3C, 1'b0, 1'b1);
        chk(rx_data == 8'h3C && rx_ready, "R1 x1 data", 32'(rx_data), 32'h3C);
        do_read();
        set_mode(2'b00, 2'b11, 1'b0, 1'b0);
        send_char(8'hC3, 1'b0, 1'b1);
        chk(rx_data == 8'hC3 && rx_ready, "R1 code00 data", 32'(rx_data), 32'hC3);
        do_read();
        set_mode(2'b11, 2'b10, 1'b1, 1'b1);
        send_char(8'h5A, 1'b0, 1'b1);
        chk(rx_data == 8'h5A && rx_ready, "R1 x64 data", 32'(rx_data), 32'h5A);
        chk(err_parity == 1'b0, "R3 good even parity", 32'(err_parity), 0);
        do_read();
    endtask

    task automatic t_lengths();
        set_mode(2'b10, 2'b00, 1'b0, 1'b0);
        send_char(8'hFF, 1'b0, 1'b1);
        chk(rx_data == 8'h1F, "R2 len5", 32'(rx_data), 32'h1F);
        do_read();
        set_mode(2'b10, 2'b01, 1'b0, 1'b0);
        send_char(8'h2B, 1'b0, 1'b1);
        chk(rx_data == 8'h2B, "R2 len6", 32'(rx_data), 32'h2B);
        do_read();
    endtask

    task automatic t_parity_sticky();
        set_mode(2'b10, 2'b11, 1'b1, 1'b0);
        send_char(8'h96, 1'b1, 1'b1);
        chk(err_parity == 1'b1, "R3 odd parity mismatch", 32'(err_parity), 1);
        do_read();
        send_char(8'h96, 1'b0, 1'b1);
        chk(err_parity == 1'b1, "R7 sticky after good char", 32'(err_parity), 1);
        chk(rx_data == 8'h96, "R3 data kept", 32'(rx_data), 32'h96);
        do_read();
        do_clear();
        chk(err_parity == 1'b0, "R7 clear", 32'(err_parity), 0);
    endtask

    task automatic t_frame();
        set_mode(2'b10, 2'b11, 1'b0, 1'b0);
        send_char(8'h4E, 1'b0, 1'b0);
        chk(err_frame == 1'b1, "R4 frame error", 32'(err_frame), 1);
        chk(rx_ready == 1'b1 && rx_data == 8'h4E, "R4 char delivered", 32'(rx_data), 32'h4E);
        do_read();
        do_clear();
        chk(err_frame == 1'b0, "R7 frame clear", 32'(err_frame), 0);
    endtask

    task automatic t_overrun();
        set_mode(2'b10, 2'b11, 1'b0, 1'b0);
        send_char(8'h11, 1'b0, 1'b1);
        chk(err_overrun == 1'b0, "R6 no overrun yet", 32'(err_overrun), 0);
        send_char(8'h22, 1'b0, 1'b1);
        chk(err_overrun == 1'b1, "R6 overrun", 32'(err_overrun), 1);
        chk(rx_data == 8'h22, "R6 overwritten", 32'(rx_data), 32'h22);
        chk(rx_ready == 1'b1, "R6 ready stays", 32'(rx_ready), 1);
        do_read();
        chk(err_overrun == 1'b1, "R7 overrun sticky over read", 32'(err_overrun), 1);
        do_clear();
        chk(err_overrun == 1'b0, "R7 overrun clear", 32'(err_overrun), 0);
    endtask

    task automatic t_disabled();
        set_mode(2'b10, 2'b11, 1'b0, 1'b0);
        rx_en = 1'b0;
        send_char(8'h77, 1'b0, 1'b1);
        chk(rx_ready == 1'b0, "R8 no ready when off", 32'(rx_ready), 0);
        chk(rx_data == 8'h22, "R8 data unchanged", 32'(rx_data), 32'h22);
        rx_en = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_false_start();
        set_mode(2'b10, 2'b11, 1'b0, 1'b0);
        rx_line = 1'b0;
        repeat (3) @(negedge clk);
        rx_line = 1'b1;
        repeat (40) @(negedge clk);
        chk(rx_ready == 1'b0, "R9 glitch ignored", 32'(rx_ready), 0);
        send_char(8'h81, 1'b0, 1'b1);
        chk(rx_ready == 1'b1 && rx_data == 8'h81, "R9 next char ok", 32'(rx_data), 32'h81);
        do_read();
        set_mode(2'b11, 2'b11, 1'b0, 1'b0);
        rx_line = 1'b0;
        repeat (20) @(negedge clk);
        rx_line = 1'b1;
        repeat (150) @(negedge clk);
        chk(rx_ready == 1'b0, "R9 x64 glitch ignored", 32'(rx_ready), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_modes();
        t_lengths();
        t_parity_sticky();
        t_frame();
        t_overrun();
        t_disabled();
        t_false_start();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule